// File: doc/BRIEF.md
# PLL fast-lock timeout sequencer

This block runs the fast-lock phase of a frequency synthesizer. Each time software writes the frequency register, the block turns on every charge-pump cell and closes both loop-filter switch groups. It then counts down three separate timeouts on a slow timer tick, which runs at one quarter of the phase-detector reference clock. When the charge-pump timeout expires, the cell count does not drop in one step. It halves once per tick until a single cell is left. Each switch group opens when its own timeout runs out.

The three timeout values are taken when the write pulse arrives. Any later change on those inputs has no effect on the sequence in progress. A new write pulse during a sequence throws the sequence away and starts over from the full cell count. Once the step-down has finished and both switches are open, the block is back in normal mode and says so on a done output.

Top module: `fastlock_seq`

## Requirements
- R1: After reset, and before any write, cell_en is 1 (bit 0 only), sw12_close and sw3_close are 0 and done is 1.
- R2: On the clock edge that samples freq_wr high, cell_en becomes all ones, both switch outputs become 1 and done becomes 0.
- R3: Timers advance on a tick that occurs every fourth clock edge after the write edge. The first tick is the fourth edge after the write edge, and no output changes between ticks.
- R4: With a charge-pump timeout T, the count of enabled cells stays at N_CELLS through tick T. It halves on each of ticks T+1 to T+log2(N_CELLS) and then holds at 1, so a timeout of 0 halves on the first tick.
- R5: cell_en is a thermometer code starting at the LSB: with n cells active, bits [n-1:0] are 1 and the rest are 0. Bit 0 is always 1.
- R6: With a timeout S for the first switch group, sw12_close stays 1 through tick S and is 0 from tick S+1 on. This does not depend on the other timers.
- R7: With a timeout S for the second switch group, sw3_close stays 1 through tick S and is 0 from tick S+1 on. This does not depend on the other timers.
- R8: Timeout inputs are sampled only on the write edge. Changes to them during a sequence have no effect on the outputs.
- R9: A write during a running sequence restarts it: all cells on, switches closed, and new timeouts counted from the new write edge.
- R10: done is 1 exactly when the cell count is 1 and both switches are open. It then holds, with all outputs stable, until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_wr | input | 1 | One-cycle pulse marking a frequency register write |
| cp_timeout | input | TW | Charge-pump current timeout, in ticks |
| sw12_timeout | input | TW | Timeout for the first loop-filter switch group |
| sw3_timeout | input | TW | Timeout for the second loop-filter switch group |
| cell_en | output | N_CELLS | Thermometer-coded charge-pump cell enables |
| sw12_close | output | 1 | First switch group closed when 1 |
| sw3_close | output | 1 | Second switch group closed when 1 |
| done | output | 1 | Fast-lock sequence complete, normal mode |

## Verification
Some properties are checked on every cycle by the assertions:
- the shape of the enable vector and the fact that bit 0 is always on;
- the effect of a write on the next cycle;
- that the cell count only holds or halves, and that outputs change only on tick edges;
- that an open switch never recloses without a write;
- that done freezes the outputs.

Other behaviour can only be shown by the bench scenarios, which compare every cycle against a tick-counted model:
- the exact tick on which each timeout fires;
- the zero-timeout case;
- that a mid-sequence change of the timeout inputs is ignored;
- that a restarting write replaces the old timeouts.

// File: rtl/fastlock_seq.sv
module fastlock_seq #(
  parameter int N_CELLS = 64,
  parameter int TW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_wr,
  input  logic [TW-1:0]     cp_timeout,
  input  logic [TW-1:0]     sw12_timeout,
  input  logic [TW-1:0]     sw3_timeout,
  output logic [N_CELLS-1:0] cell_en,
  output logic              sw12_close,
  output logic              sw3_close,
  output logic              done
);
  localparam int LOG2N = $clog2(N_CELLS);
  localparam int STW   = $clog2(LOG2N + 1);
  localparam int CW    = LOG2N + 1;
  localparam logic [STW-1:0] STEP_MAX = STW'(LOG2N);

  logic [1:0]     div;
  logic           tick;
  logic [TW-1:0]  cp_cnt, sw12_cnt, sw3_cnt;
  logic           cp_exp;
  logic [STW-1:0] step;
  logic [CW-1:0]  active_n;

  assign done     = (step == STEP_MAX) && !sw12_close && !sw3_close;
  assign tick     = !done && (div == 2'd3);
  assign active_n = CW'(N_CELLS) >> step;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       div <= '0;
    else if (freq_wr) div <= '0;
    else if (!done)   div <= div + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_cnt <= '0; cp_exp <= 1'b1; step <= STEP_MAX;
    end else if (freq_wr) begin
      cp_cnt <= cp_timeout; cp_exp <= 1'b0; step <= '0;
    end else if (tick) begin
      if (!cp_exp) begin
        if (cp_cnt == '0) begin
          cp_exp <= 1'b1;
          step   <= step + 1'b1;
        end else begin
          cp_cnt <= cp_cnt - 1'b1;
        end
      end else if (step != STEP_MAX) begin
        step <= step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw12_cnt <= '0; sw12_close <= 1'b0;
    end else if (freq_wr) begin
      sw12_cnt <= sw12_timeout; sw12_close <= 1'b1;
    end else if (tick && sw12_close) begin
      if (sw12_cnt == '0) sw12_close <= 1'b0;
      else                sw12_cnt   <= sw12_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw3_cnt <= '0; sw3_close <= 1'b0;
    end else if (freq_wr) begin
      sw3_cnt <= sw3_timeout; sw3_close <= 1'b1;
    end else if (tick && sw3_close) begin
      if (sw3_cnt == '0) sw3_close <= 1'b0;
      else               sw3_cnt   <= sw3_cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    assign cell_en[i] = (CW'(i) < active_n);
  end

  p_bit0_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en[0]);

  p_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({1'b0, cell_en} + {{N_CELLS{1'b0}}, 1'b1}) == 1);

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    freq_wr |=> (&cell_en) && sw12_close && sw3_close && !done);

  p_halve_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_wr |=> ($countones(cell_en) == $countones($past(cell_en))) ||
                 ($countones(cell_en) * 2 == $countones($past(cell_en))));

  p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!freq_wr && div != 2'd3) |=> $stable(cell_en) && $stable(sw12_close) && $stable(sw3_close));

  p_sw12_stay_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!freq_wr && !sw12_close) |=> !sw12_close);

  p_sw3_stay_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!freq_wr && !sw3_close) |=> !sw3_close);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !freq_wr) |=> done && $stable(cell_en));
endmodule

// File: tb/fastlock_seq_tb.sv
module fastlock_seq_tb;
  localparam int N  = 64;
  localparam int LG = 6;
  localparam int TW = 8;

  logic clk = 1'b0, rst_n = 1'b0, freq_wr = 1'b0;
  logic [TW-1:0] cp_t = '0, s12_t = '0, s3_t = '0;
  logic [N-1:0] cell_en;
  logic sw12_close, sw3_close, done;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fastlock_seq #(.N_CELLS(N), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr),
    .cp_timeout(cp_t), .sw12_timeout(s12_t), .sw3_timeout(s3_t),
    .cell_en(cell_en), .sw12_close(sw12_close), .sw3_close(sw3_close), .done(done));

  function automatic logic [N-1:0] therm(input int n);
    logic [N:0] v;
    v = ({{N{1'b0}}, 1'b1} << n) - 1;
    return v[N-1:0];
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_reset();
    chk("R1 cells", cell_en, therm(1));
    chk("R1 sw12", N'(sw12_close), N'(0));
    chk("R1 sw3", N'(sw3_close), N'(0));
    chk("R1 done", N'(done), N'(1));
  endtask

  // write at a negedge, then compare each later cycle with the tick model
  task automatic run_seq(input string tag, input int t, input int s1, input int s2,
                         input int limit, input bit disturb);
    int kmax, ncyc;
    kmax = t + LG;
    if (s1 + 1 > kmax) kmax = s1 + 1;
    if (s2 + 1 > kmax) kmax = s2 + 1;
    ncyc = 4 * (kmax + 2);
    if (limit > 0) ncyc = limit;
    cp_t = TW'(t); s12_t = TW'(s1); s3_t = TW'(s2); freq_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    freq_wr = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      int k, sh;
      k  = c / 4;
      sh = (k <= t) ? 0 : ((k - t > LG) ? LG : k - t);
      if (c == 0) begin
        chk({tag, " R2 cells"}, cell_en, {N{1'b1}});
        chk({tag, " R2 done"}, N'(done), N'(0));
      end
      chk({tag, " R3 R4 R5 cells"}, cell_en, therm(N >> sh));
      chk({tag, " R6 sw12"}, N'(sw12_close), N'(k <= s1));
      chk({tag, " R7 sw3"}, N'(sw3_close), N'(k <= s2));
      chk({tag, " R10 done"}, N'(done), N'((k >= t + LG) && (k > s1) && (k > s2)));
      if (disturb && c == 2) begin
        cp_t = 8'd200; s12_t = 8'd0; s3_t = 8'd150;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset();
    run_seq("R3 zero-timeout", 0, 7, 7, 0, 1'b0);
    run_seq("R4 nominal", 5, 12, 12, 0, 1'b0);
    run_seq("R6 R7 split", 3, 2, 14, 0, 1'b0);
    run_seq("R7 R6 swapped", 2, 11, 0, 0, 1'b0);
    run_seq("R8 sampled", 4, 11, 9, 0, 1'b1);
    run_seq("R9 pre", 6, 13, 13, 22, 1'b0);
    run_seq("R9 restart", 1, 3, 8, 0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 hold cells", cell_en, therm(1));
    chk("R10 hold done", N'(done), N'(1));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule